// File: doc/BRIEF.md
# Parallel SAR Converter Interface Core

This core is the digital half of a 12-bit successive-approximation converter that sits on an 8-bit parallel host bus. The host selects it with an active-low chip select and writes a control byte with an active-low write strobe. That byte sets the input channel, the single-ended or paired input mode, the unipolar or bipolar coding, two auxiliary mode bits for the analog side, and how acquisition ends. The core then drives the track/hold control and walks a 12-step binary search. Each trial code is presented to the analog side, and a single comparator bit comes back.

Acquisition ends in one of two ways. In internal mode the core counts converter-clock ticks. A tick is a one-cycle pulse that marks a falling edge of the converter clock. In external mode acquisition lasts until the host issues a second write strobe. When the search finishes, the active-low interrupt falls. The host then reads the result in two pieces over the 8-bit bus, using a high-byte select. The tri-state bus is modelled as separate data-in, data-out and output-enable signals.

Top module: `adc_sar_port`

## Requirements
- R1: After reset, int_n is 1, dout_oe is 0, track is 0 and dout is 0.
- R2: A write rising edge with cs_n low latches din as the control byte. Its fields are chan = bits 2:0, pair mode = bit 3, bipolar = bit 4, external acquisition = bit 5 and aux_mode = bits 7:6. track is 1 one clock after the edge is sampled, and bipolar and aux_mode follow the latched fields.
- R3: With bit 3 clear, neg_is_com is 1, mux_pos equals chan and mux_neg is 0. With bit 3 set, neg_is_com is 0, mux_pos equals chan and mux_neg equals chan with bit 0 inverted, so channels pair as 0/1, 2/3, 4/5 and 6/7.
- R4: With bit 5 clear, track stays 1 through three cnv_tick pulses after the control write. It falls on the clock of the fourth pulse, however many cycles lie between pulses.
- R5: With bit 5 set, track stays 1 regardless of cnv_tick until the next write rising edge with cs_n low. That edge starts conversion and its din value is ignored.
- R6: Conversion tests one bit per cnv_tick, from bit 11 down to bit 0. The first trial code on dac_code is 0x800, and a bit is kept when cmp_in is 1. int_n falls on the clock of the twelfth tick after hold begins.
- R7: int_n returns to 1 on a read falling edge with cs_n low, and on every new control write.
- R8: The bus data is registered one clock after the read signals. With hben = 1 it carries the upper four result bits on lines 3:0 with lines 7:4 at 0. With hben = 0 it carries the lower eight result bits.
- R9: dout_oe is 1 only while both cs_n and rd_n are low, and it is 0 one clock after cs_n or rd_n returns high.
- R10: A control write during a conversion aborts it. track returns to 1, int_n stays 1, the new byte takes effect and a fresh acquisition and conversion follow.
- R11: A write strobe with cs_n high changes nothing: the control fields, track and int_n keep their values and the stored result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; rising edge acts |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | 1 selects upper result nibble, 0 lower byte |
| cnv_tick | input | 1 | One-cycle pulse per converter-clock falling edge |
| cmp_in | input | 1 | Comparator decision for current trial code |
| din | input | 8 | Bus data toward the core |
| dout | output | 8 | Bus data from the core |
| dout_oe | output | 1 | Bus output enable |
| int_n | output | 1 | Result-ready interrupt, active low |
| track | output | 1 | 1 while the track/hold samples |
| mux_pos | output | 3 | Positive input channel |
| mux_neg | output | 3 | Negative input channel in pair mode, else 0 |
| neg_is_com | output | 1 | Negative input taken from common pin |
| bipolar | output | 1 | Bipolar coding selected |
| aux_mode | output | 2 | Auxiliary mode bits for the analog side |
| dac_code | output | 12 | Current trial code for the comparator |

## Verification
The bench drives on falling clock edges and samples on falling edges. A write edge is acted on at the first rising edge after wr_n rises, and track is checked in the sample that immediately follows. With ticks on every cycle, track falls four samples after that, and int_n falls sixteen samples after the write: four cycles of acquisition and twelve search steps. In external mode int_n falls twelve samples after the second strobe. Bus data and the output enable are checked one sample after cs_n and rd_n change, because each passes through one register. The gated-tick test counts pulses instead of cycles, so the four-pulse rule is checked apart from the cycle count.

// File: rtl/adc_sar_port_pkg.sv
`timescale 1ns/1ps
package adc_sar_port_pkg;
    localparam int RES_W     = 12;
    localparam int BUS_W     = 8;
    localparam int CH_W      = 3;
    localparam int ACQ_TICKS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    // Control byte; bit 5 position is behaviour (acquisition select)
    typedef struct packed {
        logic [1:0]      aux;
        logic            ext_acq;
        logic            bip;
        logic            pair;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    function automatic logic [CH_W-1:0] pair_partner(input logic [CH_W-1:0] ch);
        return ch ^ {{(CH_W-1){1'b0}}, 1'b1};
    endfunction
endpackage

// File: rtl/adc_sar_port_strobe.sv
`timescale 1ns/1ps
module adc_sar_port_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_evt,
    output logic rd_evt
);
    logic wr_q;
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    assign wr_evt = wr_n & ~wr_q & ~cs_n;
    assign rd_evt = ~rd_n & rd_q & ~cs_n;
endmodule

// File: rtl/adc_sar_port_seq.sv
`timescale 1ns/1ps
module adc_sar_port_seq
    import adc_sar_port_pkg::*;
#(
    parameter int TICKS = ACQ_TICKS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_evt,
    input  logic        rd_evt,
    input  logic        tick,
    input  logic        sar_done,
    input  logic [7:0]  din,
    output ctrl_t       cfg,
    output logic        start,
    output logic        abort,
    output logic        track,
    output logic        int_n
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             ext_end;
    logic             ctrl_wr;
    logic             int_end;

    assign ext_end = wr_evt && (state == ST_ACQ) && cfg.ext_acq;
    assign ctrl_wr = wr_evt && !ext_end;
    assign int_end = (state == ST_ACQ) && !cfg.ext_acq && tick && (cnt == LAST);
    assign start   = !ctrl_wr && (ext_end || int_end);
    assign abort   = ctrl_wr && (state == ST_CONV);
    assign track   = (state == ST_ACQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg   <= '0;
            cnt   <= '0;
            int_n <= 1'b1;
        end else if (ctrl_wr) begin
            state <= ST_ACQ;
            cfg   <= ctrl_t'(din);
            cnt   <= '0;
            int_n <= 1'b1;
        end else begin
            if (rd_evt)
                int_n <= 1'b1;
            case (state)
                ST_ACQ: begin
                    if (start)
                        state <= ST_CONV;
                    else if (tick && !cfg.ext_acq)
                        cnt <= cnt + 1'b1;
                end
                ST_CONV: begin
                    if (sar_done) begin
                        state <= ST_DONE;
                        int_n <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_sar_port_sar.sv
`timescale 1ns/1ps
module adc_sar_port_sar
    import adc_sar_port_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic         tick,
    input  logic         cmp_in,
    output logic         done,
    output logic [W-1:0] trial,
    output logic [W-1:0] result
);
    logic [W-1:0] acc;
    logic [W-1:0] mask;
    logic         busy;
    logic [W-1:0] next_acc;

    assign next_acc = acc | (cmp_in ? mask : '0);
    assign trial    = acc | mask;
    assign done     = busy && tick && mask[0] && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            mask   <= '0;
            busy   <= 1'b0;
            result <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            mask <= '0;
        end else if (start) begin
            busy <= 1'b1;
            acc  <= '0;
            mask <= {1'b1, {(W-1){1'b0}}};
        end else if (busy && tick) begin
            acc  <= next_acc;
            mask <= mask >> 1;
            if (mask[0]) begin
                busy   <= 1'b0;
                result <= next_acc;
            end
        end
    end
endmodule

// File: rtl/adc_sar_port_bus.sv
`timescale 1ns/1ps
module adc_sar_port_bus
    import adc_sar_port_pkg::*;
#(
    parameter int W  = RES_W,
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          hben,
    input  logic [W-1:0]  result,
    output logic [BW-1:0] dout,
    output logic          oe
);
    localparam int HI_W = W - BW;

    logic [BW-1:0] hi_word;
    assign hi_word = {{(BW-HI_W){1'b0}}, result[W-1:BW]};

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            oe   <= 1'b0;
        end else begin
            oe   <= ~cs_n & ~rd_n;
            dout <= hben ? hi_word : result[BW-1:0];
        end
    end
endmodule

// File: rtl/adc_sar_port.sv
`timescale 1ns/1ps
module adc_sar_port
    import adc_sar_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              hben,
    input  logic              cnv_tick,
    input  logic              cmp_in,
    input  logic [BUS_W-1:0]  din,
    output logic [BUS_W-1:0]  dout,
    output logic              dout_oe,
    output logic              int_n,
    output logic              track,
    output logic [CH_W-1:0]   mux_pos,
    output logic [CH_W-1:0]   mux_neg,
    output logic              neg_is_com,
    output logic              bipolar,
    output logic [1:0]        aux_mode,
    output logic [RES_W-1:0]  dac_code
);
    logic             wr_evt;
    logic             rd_evt;
    logic             start;
    logic             abort;
    logic             sar_done;
    logic [RES_W-1:0] result;
    ctrl_t            cfg;

    adc_sar_port_strobe u_strobe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .wr_evt(wr_evt), .rd_evt(rd_evt)
    );

    adc_sar_port_seq #(.TICKS(ACQ_TICKS)) u_seq (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .rd_evt(rd_evt),
        .tick(cnv_tick), .sar_done(sar_done), .din(din), .cfg(cfg),
        .start(start), .abort(abort), .track(track), .int_n(int_n)
    );

    adc_sar_port_sar #(.W(RES_W)) u_sar (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .tick(cnv_tick),
        .cmp_in(cmp_in), .done(sar_done), .trial(dac_code), .result(result)
    );

    adc_sar_port_bus #(.W(RES_W), .BW(BUS_W)) u_bus (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
        .result(result), .dout(dout), .oe(dout_oe)
    );

    assign mux_pos    = cfg.chan;
    assign neg_is_com = ~cfg.pair;
    assign mux_neg    = cfg.pair ? pair_partner(cfg.chan) : '0;
    assign bipolar    = cfg.bip;
    assign aux_mode   = cfg.aux;
endmodule

// File: rtl/adc_sar_port_chk.sv
`timescale 1ns/1ps
module adc_sar_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        wr_n,
    input logic        rd_n,
    input logic        dout_oe,
    input logic        int_n,
    input logic        track,
    input logic [11:0] dac_code
);
    p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !dout_oe);

    p_wr_clears_int_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_n) && !cs_n) |=> int_n);

    p_rd_clears_int_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) && !cs_n) |=> int_n);

    p_msb_first_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(track) |-> (dac_code == 12'h800));

    p_int_after_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> (!track && !$past(track)));
endmodule

bind adc_sar_port adc_sar_port_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .dout_oe(dout_oe), .int_n(int_n), .track(track), .dac_code(dac_code)
);

// File: tb/adc_sar_port_bench.sv
`timescale 1ns/1ps
module adc_sar_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
    logic        cnv_tick = 1'b1;
    logic [7:0]  din = 8'h00;
    logic [11:0] vin = 12'h000;
    logic        cmp_in;
    logic [7:0]  dout;
    logic        dout_oe, int_n, track, neg_is_com, bipolar;
    logic [2:0]  mux_pos, mux_neg;
    logic [1:0]  aux_mode;
    logic [11:0] dac_code;
    int          total = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    // analog model: trial code at or below input voltage keeps the bit
    assign cmp_in = (dac_code <= vin);

    adc_sar_port u_adc_sar_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hben(hben), .cnv_tick(cnv_tick), .cmp_in(cmp_in), .din(din),
        .dout(dout), .dout_oe(dout_oe), .int_n(int_n), .track(track),
        .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_is_com(neg_is_com),
        .bipolar(bipolar), .aux_mode(aux_mode), .dac_code(dac_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = b;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic read_part(input logic hb, input int exp);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; hben = hb;
        @(negedge clk);
        chk("R9 oe on read", int'(dout_oe), 1);
        chk(hb ? "R8 high nibble" : "R8 low byte", int'(dout), exp);
        chk("R7 int cleared by read", int'(int_n), 1);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        chk("R9 oe off", int'(dout_oe), 0);
    endtask

    task automatic read_result(input logic [11:0] v);
        read_part(1'b0, int'(v[7:0]));
        read_part(1'b1, int'(v[11:8]));
    endtask

    task automatic chk_cfg(input logic [7:0] b);
        chk("R3 mux_pos", int'(mux_pos), int'(b[2:0]));
        chk("R3 neg_is_com", int'(neg_is_com), int'(!b[3]));
        chk("R3 mux_neg", int'(mux_neg), b[3] ? int'(b[2:0] ^ 3'b001) : 0);
        chk("R2 bipolar", int'(bipolar), int'(b[4]));
        chk("R2 aux_mode", int'(aux_mode), int'(b[7:6]));
    endtask

    // after do_write returns, with a tick every cycle
    task automatic follow_internal(input string tag);
        chk({tag, " R2 track after write"}, int'(track), 1);
        repeat (3) @(negedge clk);
        chk({tag, " R4 track through 3 ticks"}, int'(track), 1);
        @(negedge clk);
        chk({tag, " R4 hold on 4th tick"}, int'(track), 0);
        repeat (11) @(negedge clk);
        chk({tag, " R6 int before 12th step"}, int'(int_n), 1);
        @(negedge clk);
        chk({tag, " R6 int at 12th step"}, int'(int_n), 0);
    endtask

    task automatic conv_int(input logic [7:0] b, input logic [11:0] v);
        vin = v;
        do_write(b);
        chk_cfg(b);
        follow_internal("conv");
        read_result(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL all watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 int_n", int'(int_n), 1);
        chk("R1 oe", int'(dout_oe), 0);
        chk("R1 track", int'(track), 0);
        chk("R1 dout", int'(dout), 0);

        // R9: chip select alone does not enable the bus
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        chk("R9 oe needs read", int'(dout_oe), 0);
        cs_n = 1'b1;

        // sweep of inputs and internal-acquisition control bytes
        for (int v = 0; v < 4096; v += 13) begin
            logic [7:0] b;
            b = 8'((v / 13) * 37) & 8'hDF;
            conv_int(b, 12'(v));
        end
        conv_int(8'hC8, 12'hFFF);
        conv_int(8'h17, 12'h7FF);
        conv_int(8'h0E, 12'h800);

        // R5 external acquisition
        vin = 12'h9A5;
        do_write(8'h2A);
        chk_cfg(8'h2A);
        chk("R5 track after write", int'(track), 1);
        repeat (20) @(negedge clk);
        chk("R5 track held by ticks", int'(track), 1);
        chk("R5 int idle", int'(int_n), 1);
        do_write(8'h05);
        chk("R5 second strobe holds", int'(track), 0);
        chk("R5 data of second strobe ignored", int'(mux_pos), 2);
        repeat (11) @(negedge clk);
        chk("R6 ext int before 12th", int'(int_n), 1);
        @(negedge clk);
        chk("R6 ext int at 12th", int'(int_n), 0);
        read_result(12'h9A5);

        // R4 with gated ticks
        cnv_tick = 1'b0;
        vin = 12'h123;
        do_write(8'h01);
        repeat (10) @(negedge clk);
        chk("R4 no ticks keeps track", int'(track), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cnv_tick = 1'b1;
            @(negedge clk); cnv_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        chk("R4 three pulses keep track", int'(track), 1);
        @(negedge clk); cnv_tick = 1'b1;
        @(negedge clk); cnv_tick = 1'b0;
        chk("R4 fourth pulse holds", int'(track), 0);
        cnv_tick = 1'b1;
        for (int k = 0; k < 30 && int_n; k++) @(negedge clk);
        chk("R6 gated conversion done", int'(int_n), 0);
        read_result(12'h123);

        // R10 abort during conversion
        vin = 12'hABC;
        do_write(8'h00);
        repeat (8) @(negedge clk);
        chk("R10 converting", int'(track), 0);
        vin = 12'h456;
        do_write(8'h13);
        chk("R10 int stays high", int'(int_n), 1);
        chk_cfg(8'h13);
        follow_internal("R10 abort");
        read_result(12'h456);

        // R11 write with chip select high
        vin = 12'h03C;
        do_write(8'h02);
        repeat (20) @(negedge clk);
        chk("R11 setup done", int'(int_n), 0);
        @(negedge clk); din = 8'hFF; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 track unchanged", int'(track), 0);
        chk("R11 int unchanged", int'(int_n), 0);
        chk("R11 mux_pos unchanged", int'(mux_pos), 2);
        chk("R11 aux unchanged", int'(aux_mode), 0);
        read_result(12'h03C);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule